// File: doc/BRIEF.md
# Host-Arbitrated DMA Bus Master

This block lets a protocol engine borrow a system RAM bus that belongs to the host processor. The engine hands over a start word address, a word count and a direction. The block then pulls an active-low request line, waits for the host to answer on an active-low grant line, and takes the bus by pulling an active-low acknowledge. While acknowledge is low it drives the address, the write data and one active-low strobe per word. Each word takes two cycles: one with the strobe low and one with it high.

The RAM space is wider than the engine's 16-bit word address. The upper address bits come from a page register that the host writes. While the block does not own the bus, all of its bus drivers are disabled through a single output enable, so no external isolation buffers are needed. The data lines are driven only when that enable is high and the transfer is a write.

If the host takes its grant away during a burst, the word in flight still finishes. The block then gives the bus back and raises its request again for the words that remain.

Top module: `hostbus_dma_arb`

## Requirements
- R1: After a synchronous reset, dma_req_n, dma_ack_n and bus_strb_n are 1, and bus_oe and eng_busy are 0.
- R2: While idle, an eng_start pulse with a non-zero eng_len drives dma_req_n to 0 and eng_busy to 1 on the next clock edge.
- R3: dma_ack_n falls only on an edge where dma_grant_n is sampled low. The first bus_strb_n low occurs on that same edge.
- R4: dma_req_n returns to 1 one clock after dma_ack_n falls.
- R5: Each word holds bus_strb_n low for exactly one cycle, followed by at least one cycle with it high. During the low cycle, bus_addr[15:0] equals the start address plus the word index, wrapping modulo 2^16.
- R6: During a write strobe, bus_rd_wr is 0 and bus_wdata equals eng_wdata as sampled on the edge that starts that strobe. During a read strobe, bus_rd_wr is 1, and bus_rdata is captured into eng_rdata on the edge that ends the strobe. In both directions, eng_word_done is 1 for the single cycle after each strobe.
- R7: While grant stays low, dma_ack_n stays 0 for the whole burst. It returns to 1 one clock after the last strobe ends, on the same edge that clears eng_busy. The burst produces exactly eng_len strobes.
- R8: bus_oe is 1 exactly when dma_ack_n is 0, and bus_strb_n is 0 only while dma_ack_n is 0.
- R9: Grant is sampled on the edge that ends each word's high cycle. If grant is high there and words remain, dma_ack_n goes to 1 and dma_req_n goes to 0 on that same edge. The burst then resumes at the next word after grant returns.
- R10: An eng_start with eng_len equal to 0 is ignored: no request is raised and eng_busy stays 0.
- R11: An eng_start while eng_busy is 1 is ignored: the running burst keeps its addresses and count, and no request follows it.
- R12: A page_we write loads page_wdata on the next edge. That register value appears as bus_addr[19:16] for all later words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_we | input | 1 | Host write strobe for the page register |
| page_wdata | input | PAGE_W | New page value |
| eng_start | input | 1 | Engine starts a burst |
| eng_addr | input | LOW_AW | Start word address |
| eng_len | input | LEN_W | Number of words in the burst |
| eng_write | input | 1 | 1 = write burst, 0 = read burst |
| eng_wdata | input | DATA_W | Data for the next word to be written |
| eng_busy | output | 1 | A burst is in progress |
| eng_word_done | output | 1 | One-cycle pulse after each word |
| eng_rdata | output | DATA_W | Last word read from the bus |
| dma_req_n | output | 1 | Active-low bus request to the host |
| dma_grant_n | input | 1 | Active-low bus grant from the host |
| dma_ack_n | output | 1 | Active-low bus-owned acknowledge |
| bus_oe | output | 1 | Enable for the address and control drivers (and the data drivers on writes) |
| bus_addr | output | LOW_AW+PAGE_W | Word address {page, low address} |
| bus_wdata | output | DATA_W | Write data to RAM |
| bus_rdata | input | DATA_W | Read data from RAM |
| bus_strb_n | output | 1 | Active-low word strobe |
| bus_rd_wr | output | 1 | 1 = read, 0 = write |

## Verification
Two things can fall on the same edge: the end of a word and the host taking grant away. On that edge the block must finish the word, drop acknowledge and the drivers, and raise its request again, all together. The host model in the bench pulls grant high at random points while acknowledge is low, so some withdrawals land in the strobe cycle and some in the gap cycle. Some of them also hit the last word, where no new request may follow. Each release edge is judged against the number of strobes the bench has counted so far. Fewer strobes than requested calls for a fresh request with grant high. A full count calls for a quiet request line and a cleared busy flag.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_STB  = 2'd2,
    HS_GAP  = 2'd3
  } hs_state_e;
endpackage

// File: rtl/dma_page_reg.sv
module dma_page_reg #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk) begin
    if (rst)     page_q <= '0;
    else if (we) page_q <= wdata;
  end

  // R12
  page_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> page_q == $past(wdata));
endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
  import dma_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_ok,
  input  logic grant_n,
  input  logic more,
  output logic req_n,
  output logic ack_n,
  output logic oe,
  output logic strb_n,
  output logic busy,
  output logic step,
  output logic drive
);
  hs_state_e state_q;

  always_comb begin
    busy  = (state_q != HS_IDLE);
    step  = (state_q == HS_STB);
    drive = !grant_n && ((state_q == HS_REQ) || (state_q == HS_GAP && more));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_IDLE;
      req_n   <= 1'b1;
      ack_n   <= 1'b1;
      oe      <= 1'b0;
      strb_n  <= 1'b1;
    end else begin
      case (state_q)
        HS_IDLE: if (start_ok) begin
          state_q <= HS_REQ;
          req_n   <= 1'b0;
        end
        HS_REQ: if (!grant_n) begin
          state_q <= HS_STB;
          ack_n   <= 1'b0;
          oe      <= 1'b1;
          strb_n  <= 1'b0;
        end
        HS_STB: begin
          state_q <= HS_GAP;
          strb_n  <= 1'b1;
          req_n   <= 1'b1;
        end
        default: begin
          if (more && !grant_n) begin
            state_q <= HS_STB;
            strb_n  <= 1'b0;
          end else begin
            ack_n   <= 1'b1;
            oe      <= 1'b0;
            if (more) begin
              state_q <= HS_REQ;
              req_n   <= 1'b0;
            end else begin
              state_q <= HS_IDLE;
            end
          end
        end
      endcase
    end
  end

  // R3
  ack_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> !$past(grant_n));
  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |=> req_n);
  // R8
  strb_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !strb_n |-> (!ack_n && oe));
  // R8
  oe_tracks_ack_chk: assert property (@(posedge clk) disable iff (rst)
    oe == !ack_n);
  // R7
  release_after_strb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_n) |-> ($past(strb_n) && !$past(strb_n, 2)));
endmodule

// File: rtl/dma_word_seq.sv
module dma_word_seq #(
  parameter int LOW_AW = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOW_AW-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              ld_write,
  input  logic              step,
  input  logic              drive,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [LOW_AW-1:0] addr_q,
  output logic              more,
  output logic              write_q,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);
  logic [LEN_W-1:0] rem_q;

  assign more = (rem_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      rem_q   <= '0;
      write_q <= 1'b0;
      data_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= step;
      if (load) begin
        addr_q  <= ld_addr;
        rem_q   <= ld_len;
        write_q <= ld_write;
      end else if (step) begin
        addr_q <= addr_q + 1'b1;
        rem_q  <= rem_q - 1'b1;
        if (!write_q) rdata_q <= rdata_in;
      end
      if (drive) data_q <= wdata_in;
    end
  end

  // R7
  rem_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> rem_q != '0);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: rtl/hostbus_dma_arb.sv
module hostbus_dma_arb #(
  parameter int DATA_W = 16,
  parameter int LOW_AW = 16,
  parameter int PAGE_W = 4,
  parameter int LEN_W  = 8,
  localparam int ADDR_W = LOW_AW + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic              eng_start,
  input  logic [LOW_AW-1:0] eng_addr,
  input  logic [LEN_W-1:0]  eng_len,
  input  logic              eng_write,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic              eng_busy,
  output logic              eng_word_done,
  output logic [DATA_W-1:0] eng_rdata,
  output logic              dma_req_n,
  input  logic              dma_grant_n,
  output logic              dma_ack_n,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_strb_n,
  output logic              bus_rd_wr
);
  logic [PAGE_W-1:0] page_q;
  logic [LOW_AW-1:0] addr_q;
  logic              start_ok, more, step, drive, write_q;

  assign start_ok = eng_start && !eng_busy && (eng_len != '0);

  dma_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .we(page_we), .wdata(page_wdata), .page_q(page_q)
  );

  dma_hs_fsm u_fsm (
    .clk(clk), .rst(rst), .start_ok(start_ok), .grant_n(dma_grant_n),
    .more(more), .req_n(dma_req_n), .ack_n(dma_ack_n), .oe(bus_oe),
    .strb_n(bus_strb_n), .busy(eng_busy), .step(step), .drive(drive)
  );

  dma_word_seq #(.LOW_AW(LOW_AW), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .load(start_ok), .ld_addr(eng_addr),
    .ld_len(eng_len), .ld_write(eng_write), .step(step), .drive(drive),
    .wdata_in(eng_wdata), .rdata_in(bus_rdata), .addr_q(addr_q),
    .more(more), .write_q(write_q), .data_q(bus_wdata),
    .rdata_q(eng_rdata), .done_q(eng_word_done)
  );

  assign bus_addr  = {page_q, addr_q};
  assign bus_rd_wr = !write_q;

  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!eng_busy && eng_start && eng_len == '0) |=> !eng_busy);
  // R2
  start_req_chk: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> (!dma_req_n && eng_busy));
endmodule

// File: tb/hostbus_dma_arb_tb.sv
module hostbus_dma_arb_tb;
  localparam int DATA_W = 16, LOW_AW = 16, PAGE_W = 4, LEN_W = 8;

  logic clk = 0, rst = 1;
  logic page_we = 0;
  logic [PAGE_W-1:0] page_wdata = '0;
  logic eng_start = 0, eng_write = 0;
  logic [LOW_AW-1:0] eng_addr = '0;
  logic [LEN_W-1:0] eng_len = '0;
  logic [DATA_W-1:0] eng_wdata = '0, bus_rdata = '0;
  logic eng_busy, eng_word_done, dma_req_n, dma_ack_n, bus_oe, bus_strb_n, bus_rd_wr;
  logic dma_grant_n = 1;
  logic [DATA_W-1:0] eng_rdata, bus_wdata;
  logic [LOW_AW+PAGE_W-1:0] bus_addr;

  hostbus_dma_arb #(.DATA_W(DATA_W), .LOW_AW(LOW_AW), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .page_we(page_we), .page_wdata(page_wdata),
    .eng_start(eng_start), .eng_addr(eng_addr), .eng_len(eng_len),
    .eng_write(eng_write), .eng_wdata(eng_wdata), .eng_busy(eng_busy),
    .eng_word_done(eng_word_done), .eng_rdata(eng_rdata),
    .dma_req_n(dma_req_n), .dma_grant_n(dma_grant_n), .dma_ack_n(dma_ack_n),
    .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_strb_n(bus_strb_n), .bus_rd_wr(bus_rd_wr)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit mon_en = 0, wd_en = 0;
  logic [LOW_AW-1:0] exp_base = '0;
  logic [PAGE_W-1:0] exp_page = '0;
  int exp_len = 0, stb_k = 0, wd_k = 0, tag = 0, gdelay = 0;
  bit exp_wr = 0;
  logic prev_ack = 1, prev2_ack = 1, prev_strb = 1, prev2_strb = 1;

  function automatic logic [15:0] wfn(input int t, input int k);
    return 16'(32'hA000 ^ (k * 32'h0123) ^ (t * 32'h0101));
  endfunction

  function automatic logic [15:0] rfn(input logic [19:0] a);
    return a[15:0] ^ 16'h5A5A ^ {a[19:16], 12'h000};
  endfunction

  function automatic logic [19:0] exp_addr(input int k);
    return {exp_page, 16'(exp_base + 16'(k))};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // monitor and host model
  always @(negedge clk) begin
    if (mon_en) begin
      chk(bus_oe == !dma_ack_n, "R8 oe vs ack", {31'd0, bus_oe}, {31'd0, !dma_ack_n});
      if (!bus_strb_n) begin
        chk(!dma_ack_n, "R8 strobe outside ack", {31'd0, dma_ack_n}, 0);
        chk(prev_strb, "R5 strobe longer than one cycle", {31'd0, prev_strb}, 1);
        chk(bus_addr == exp_addr(stb_k), "R5 R12 word address", {12'd0, bus_addr}, {12'd0, exp_addr(stb_k)});
        chk(bus_rd_wr == !exp_wr, "R6 direction", {31'd0, bus_rd_wr}, {31'd0, !exp_wr});
        if (exp_wr) chk(bus_wdata == wfn(tag, stb_k), "R6 write data", {16'd0, bus_wdata}, {16'd0, wfn(tag, stb_k)});
        bus_rdata = rfn(bus_addr);
        stb_k++;
      end
      if (prev_ack && !dma_ack_n) begin
        chk(!dma_grant_n, "R3 ack without grant", {31'd0, dma_grant_n}, 0);
        chk(!bus_strb_n, "R3 first strobe with ack", {31'd0, bus_strb_n}, 0);
      end
      if (!prev_ack && prev2_ack)
        chk(dma_req_n, "R4 request not dropped", {31'd0, dma_req_n}, 1);
      if (!prev_ack && dma_ack_n) begin
        chk(prev_strb && !prev2_strb, "R7 release timing", {30'd0, prev2_strb, prev_strb}, 2'b01);
        if (stb_k < exp_len) begin
          chk(!dma_req_n, "R9 re-request after withdrawal", {31'd0, dma_req_n}, 0);
          chk(dma_grant_n, "R9 release with grant held", {31'd0, dma_grant_n}, 1);
        end else begin
          chk(dma_req_n && !eng_busy, "R7 end of burst", {30'd0, dma_req_n, eng_busy}, 2'b10);
        end
      end
      if (eng_word_done) begin
        if (!exp_wr) chk(eng_rdata == rfn(exp_addr(wd_k)), "R6 read data", {16'd0, eng_rdata}, {16'd0, rfn(exp_addr(wd_k))});
        wd_k++;
      end
      eng_wdata = wfn(tag, wd_k);
      // host
      if (!dma_ack_n && !dma_grant_n && wd_en && ($urandom % 6 == 0)) dma_grant_n = 1;
      else if (!dma_req_n && dma_grant_n) begin
        if (gdelay == 0) begin dma_grant_n = 0; gdelay = $urandom % 4; end
        else gdelay--;
      end else if (dma_req_n && dma_ack_n) dma_grant_n = 1;
      prev2_ack = prev_ack; prev_ack = dma_ack_n;
      prev2_strb = prev_strb; prev_strb = bus_strb_n;
    end
  end

  task automatic set_page(input logic [PAGE_W-1:0] p);
    @(negedge clk); page_we = 1; page_wdata = p;
    @(negedge clk); page_we = 0; exp_page = p;
  endtask

  task automatic burst(input logic [15:0] a, input int len, input bit wr, input bit wd, input bit poke);
    @(negedge clk);
    tag++; stb_k = 0; wd_k = 0; exp_base = a; exp_len = len; exp_wr = wr; wd_en = wd;
    eng_addr = a; eng_len = LEN_W'(len); eng_write = wr; eng_start = 1;
    @(negedge clk);
    eng_start = 0;
    chk(!dma_req_n && eng_busy, "R2 request raised", {30'd0, dma_req_n, eng_busy}, 2'b01);
    if (poke) begin
      repeat (3) @(negedge clk);
      eng_addr = a ^ 16'h0F0F; eng_len = 8'd9; eng_write = !wr; eng_start = 1;
      @(negedge clk); eng_start = 0;
    end
    while (eng_busy) @(negedge clk);
    chk(stb_k == len, "R7 strobe count", stb_k, len);
    chk(wd_k == len, "R6 word_done count", wd_k, len);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(dma_req_n && !eng_busy, "R11 start while busy ignored", {30'd0, dma_req_n, eng_busy}, 2'b10);
    end
  endtask

  initial begin
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(dma_req_n && dma_ack_n && bus_strb_n && !bus_oe && !eng_busy, "R1 reset state",
        {27'd0, dma_req_n, dma_ack_n, bus_strb_n, bus_oe, eng_busy}, 5'b11100);
    mon_en = 1;
    set_page(4'h3);
    burst(16'h0100, 1, 1, 0, 0);
    burst(16'h0200, 4, 0, 0, 0);
    set_page(4'h9);
    burst(16'hFFFE, 4, 1, 0, 0);   // R5 wrap within page
    // R10 zero length
    @(negedge clk); eng_len = 0; eng_start = 1;
    @(negedge clk); eng_start = 0;
    chk(dma_req_n && !eng_busy, "R10 zero length ignored", {30'd0, dma_req_n, eng_busy}, 2'b10);
    repeat (2) @(negedge clk);
    chk(dma_req_n && !eng_busy, "R10 still idle", {30'd0, dma_req_n, eng_busy}, 2'b10);
    burst(16'h1234, 6, 0, 0, 1);   // R11
    burst(16'h4000, 10, 1, 1, 0);  // R9 withdrawals
    for (int i = 0; i < 30; i++) begin
      if ($urandom % 4 == 0) set_page(PAGE_W'($urandom));
      burst(16'($urandom), 1 + int'($urandom % 12), 1'($urandom), 1, 0);
    end
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule